// File: doc/BRIEF.md
# Sleep Mode Clock Enable Controller

This block sits beside a small processor core and decides which clock domains keep running while the core sleeps. Software sets a 3-bit mode code and a sleep-enable bit, then issues a sleep strobe; from the next cycle the block drops the enables of the domains that the chosen mode stops. It drives six enables: processor, general I/O, converter, asynchronous timer, watchdog and main oscillator. The watchdog runs from its own oscillator, so its enable stays high in every mode.

Four wake sources can end a sleep: external interrupt, two-wire address match, watchdog and asynchronous timer. Each mode accepts only some of them, and a source that the mode does not accept is ignored. The wake lines first pass through a synchronizer chain of configurable depth. Power-down and power-save stop the main oscillator, so on waking from them the block runs a warm-up phase of a programmable length before the processor clock returns. Waking from any other mode restores the processor clock on the next cycle. A one-cycle pulse marks the first cycle in which the processor clock is back.

Top module: `slp_clock_gate_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all six enables are 1 and `wake_pending` is 0.
- R2: Sleep begins only when `sleep_req` and `sleep_en` are both 1 in a running cycle. The enables then change from the next cycle. A strobe sent while `sleep_en` is 0 has no effect. A wake that arrives in the same cycle as an accepted strobe does not cancel the sleep.
- R3: Mode codes 000, 100 and 101 (idle) drop only the processor enable.
- R4: Code 001 (converter quiet) drops the processor and I/O enables. The converter, timer, watchdog and oscillator enables stay high.
- R5: Code 010 (power-down) leaves only the watchdog enable high. The processor, I/O and converter enables are never high while the oscillator enable is low.
- R6: Code 011 (power-save) leaves the watchdog and timer enables high.
- R7: Code 110 (standby) keeps the oscillator and watchdog enables high. Code 111 (extended standby) also keeps the timer enable high.
- R8: The wake sources each mode accepts are:
  - idle, power-save and extended standby accept all four sources;
  - converter quiet accepts external, watchdog and timer;
  - power-down and standby accept external, two-wire and watchdog.
  A source the mode does not accept leaves every enable unchanged.
- R9: A wake input goes through WAKE_SYNC (default 2) flops before the controller acts on it. A one-cycle wake pulse driven after edge E0 restores the processor clock after edge E3.
- R10: A wake from power-down or power-save starts a warm-up phase. During warm-up the oscillator and watchdog enables are high, the timer enable keeps its value from the mode, and the processor, I/O and converter enables are low. Warm-up lasts max(N,1) cycles, where N is `startup_cycles` sampled at the wake edge.
- R11: A wake from idle, converter quiet, standby or extended standby restores all enables on the cycle after the controller sees the synchronized wake.
- R12: `wake_pending` is 1 for exactly the first cycle in which the processor enable is back after a sleep.
- R13: The mode is latched when sleep begins. Changes to `mode_sel` and further strobes during sleep or warm-up have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Sleep mode code |
| sleep_en | input | 1 | Permits a sleep strobe to take effect |
| sleep_req | input | 1 | Sleep strobe |
| wake_ext | input | 1 | External interrupt wake |
| wake_twi | input | 1 | Two-wire address match wake |
| wake_wdt | input | 1 | Watchdog wake |
| wake_tmr | input | 1 | Asynchronous timer wake |
| startup_cycles | input | CNT_W | Oscillator warm-up length in cycles |
| cpu_clk_en | output | 1 | Processor clock enable |
| io_clk_en | output | 1 | General I/O clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| tmr_clk_en | output | 1 | Asynchronous timer clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| osc_en | output | 1 | Main oscillator enable |
| wake_pending | output | 1 | One-cycle pulse when the processor clock returns |

## Verification
Two functions can fall in the same cycle. In the first case, a synchronized wake arrives in the same cycle that a sleep strobe is accepted. The bench provokes this by holding the timer wake high before it strobes idle; the sleep must still begin, and the still-held wake then ends it one cycle later. In the second case, a new strobe arrives while `wake_pending` is high. This strobe must be accepted, and the wake tail still in the synchronizer must be ignored by the newly latched standby mode. A behavioural model is updated on each clock and compared with all outputs every cycle. Directed checks add the wake latency measured for each mode.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

   typedef enum logic [2:0] {
      MS_IDLE  = 3'b000,
      MS_QUIET = 3'b001,
      MS_PDOWN = 3'b010,
      MS_PSAVE = 3'b011,
      MS_RSVA  = 3'b100,
      MS_RSVB  = 3'b101,
      MS_STBY  = 3'b110,
      MS_XSTBY = 3'b111
   } mode_e;

   typedef struct packed {
      logic cpu;
      logic io;
      logic adc;
      logic tmr;
      logic wdt;
      logic osc;
   } dom_t;

   localparam int NUM_WAKE = 4;
   localparam int WK_EXT   = 3;
   localparam int WK_TWI   = 2;
   localparam int WK_WDT   = 1;
   localparam int WK_TMR   = 0;

   typedef enum logic [1:0] {
      PS_RUN   = 2'd0,
      PS_SLEEP = 2'd1,
      PS_WARM  = 2'd2
   } pstate_e;

   localparam dom_t DOM_ALL = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, tmr: 1'b1, wdt: 1'b1, osc: 1'b1};

endpackage

// File: rtl/slp_wake_sync.sv
module slp_wake_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("slp_wake_sync: STAGES must lie in 0..4");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("slp_wake_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] ff [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) ff[i] <= '0;
         end else begin
            ff[0] <= d;
            for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
         end
      end
      assign q = ff[STAGES-1];
   end

endmodule

// File: rtl/slp_mode_table.sv
module slp_mode_table
   import sleep_pkg::*;
(
   input  logic [2:0]          mode,
   output dom_t                keep,
   output logic [NUM_WAKE-1:0] legal,
   output logic                osc_stop
);

   always_comb begin
      keep  = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, tmr: 1'b1, wdt: 1'b1, osc: 1'b1};
      legal = '1;
      case (mode_e'(mode))
         MS_QUIET: begin
            keep  = '{cpu: 1'b0, io: 1'b0, adc: 1'b1, tmr: 1'b1, wdt: 1'b1, osc: 1'b1};
            legal = '0;
            legal[WK_EXT] = 1'b1;
            legal[WK_WDT] = 1'b1;
            legal[WK_TMR] = 1'b1;
         end
         MS_PDOWN: begin
            keep  = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, tmr: 1'b0, wdt: 1'b1, osc: 1'b0};
            legal = '1;
            legal[WK_TMR] = 1'b0;
         end
         MS_PSAVE: begin
            keep  = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, tmr: 1'b1, wdt: 1'b1, osc: 1'b0};
            legal = '1;
         end
         MS_STBY: begin
            keep  = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, tmr: 1'b0, wdt: 1'b1, osc: 1'b1};
            legal = '1;
            legal[WK_TMR] = 1'b0;
         end
         MS_XSTBY: begin
            keep  = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, tmr: 1'b1, wdt: 1'b1, osc: 1'b1};
            legal = '1;
         end
         default: begin
            keep  = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, tmr: 1'b1, wdt: 1'b1, osc: 1'b1};
            legal = '1;
         end
      endcase
      osc_stop = ~keep.osc;
   end

   // R8: every mode accepts at least three wake sources
   always_comb begin
      a_r8_enough_sources: assert ($countones(legal) >= 3)
         else $error("R8: mode %0d accepts too few wake sources", mode);
   end

endmodule

// File: rtl/slp_warmup_cnt.sv
module slp_warmup_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             last
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (run && cnt > ONE)  cnt <= cnt - ONE;
   end

   assign last = (cnt <= ONE);

   // R10: the warm-up length is captured at the wake edge
   a_r10_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val))
      else $error("R10: warm-up count not captured");

   // R10: the counter holds outside warm-up
   a_r10_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !run) |=> $stable(cnt))
      else $error("R10: warm-up count moved while idle");

endmodule

// File: rtl/slp_power_fsm.sv
module slp_power_fsm
   import sleep_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep_req,
   input  logic                sleep_en,
   input  logic [2:0]          mode_sel,
   input  logic [NUM_WAKE-1:0] wake_s,
   input  dom_t                keep,
   input  logic [NUM_WAKE-1:0] legal,
   input  logic                osc_stop,
   input  logic                cnt_last,
   output logic [2:0]          mode_q,
   output logic                warm_load,
   output logic                warm_run,
   output dom_t                dom_en,
   output logic                wake_pending
);

   pstate_e    st, st_n;
   logic [2:0] mode_n;
   logic       hit;

   assign hit = |(wake_s & legal);

   always_comb begin
      st_n      = st;
      mode_n    = mode_q;
      warm_load = 1'b0;
      case (st)
         PS_RUN: begin
            if (sleep_req && sleep_en) begin
               st_n   = PS_SLEEP;
               mode_n = mode_sel;
            end
         end
         PS_SLEEP: begin
            if (hit) begin
               if (osc_stop) begin
                  st_n      = PS_WARM;
                  warm_load = 1'b1;
               end else begin
                  st_n = PS_RUN;
               end
            end
         end
         PS_WARM: begin
            if (cnt_last) st_n = PS_RUN;
         end
         default: st_n = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= PS_RUN;
         mode_q       <= '0;
         wake_pending <= 1'b0;
      end else begin
         st           <= st_n;
         mode_q       <= mode_n;
         wake_pending <= (st_n == PS_RUN) && (st != PS_RUN);
      end
   end

   assign warm_run = (st == PS_WARM);

   always_comb begin
      case (st)
         PS_SLEEP: dom_en = keep;
         PS_WARM:  dom_en = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, tmr: keep.tmr, wdt: 1'b1, osc: 1'b1};
         default:  dom_en = DOM_ALL;
      endcase
   end

   // R12: the pulse marks a restored processor clock after a non-running cycle
   a_r12_pulse_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pending |-> (dom_en.cpu && $past(st) != PS_RUN))
      else $error("R12: wake_pending without a restore");

   // R2: sleep begins only from an enabled strobe
   a_r2_entry_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_SLEEP && $past(st) == PS_RUN) |-> $past(sleep_req && sleep_en))
      else $error("R2: sleep entered without enabled strobe");

   // R5: derived clocks never run without the oscillator
   a_r5_osc_gates_derived: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_en.osc |-> !(dom_en.cpu || dom_en.io || dom_en.adc))
      else $error("R5: derived enable high with oscillator stopped");

   // R13: the latched mode holds while not running
   a_r13_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st != PS_RUN && $past(st) != PS_RUN) |-> $stable(mode_q))
      else $error("R13: latched mode changed during sleep");

   // R8: sleep is left only on an accepted wake
   a_r8_legal_exit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == PS_SLEEP && st != PS_SLEEP) |-> $past(hit))
      else $error("R8: sleep left without accepted wake");

   // R10: warm-up ends only when the count is spent
   a_r10_warm_exit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == PS_WARM && st == PS_RUN) |-> $past(cnt_last))
      else $error("R10: warm-up ended early");

endmodule

// File: rtl/slp_clock_gate_ctrl.sv
module slp_clock_gate_ctrl
   import sleep_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int WAKE_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_sel,
   input  logic             sleep_en,
   input  logic             sleep_req,
   input  logic             wake_ext,
   input  logic             wake_twi,
   input  logic             wake_wdt,
   input  logic             wake_tmr,
   input  logic [CNT_W-1:0] startup_cycles,
   output logic             cpu_clk_en,
   output logic             io_clk_en,
   output logic             adc_clk_en,
   output logic             tmr_clk_en,
   output logic             wdt_clk_en,
   output logic             osc_en,
   output logic             wake_pending
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("slp_clock_gate_ctrl: CNT_W must lie in 1..32");
   end

   logic [NUM_WAKE-1:0] wake_raw, wake_s, legal;
   logic [2:0]          mode_q;
   dom_t                keep, dom_en;
   logic                osc_stop, cnt_last, warm_load, warm_run;

   always_comb begin
      wake_raw         = '0;
      wake_raw[WK_EXT] = wake_ext;
      wake_raw[WK_TWI] = wake_twi;
      wake_raw[WK_WDT] = wake_wdt;
      wake_raw[WK_TMR] = wake_tmr;
   end

   slp_wake_sync #(.STAGES(WAKE_SYNC), .WIDTH(NUM_WAKE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wake_raw),
      .q     (wake_s)
   );

   slp_mode_table u_table (
      .mode     (mode_q),
      .keep     (keep),
      .legal    (legal),
      .osc_stop (osc_stop)
   );

   slp_warmup_cnt #(.CNT_W(CNT_W)) u_warm (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (warm_load),
      .load_val (startup_cycles),
      .run      (warm_run),
      .last     (cnt_last)
   );

   slp_power_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_req    (sleep_req),
      .sleep_en     (sleep_en),
      .mode_sel     (mode_sel),
      .wake_s       (wake_s),
      .keep         (keep),
      .legal        (legal),
      .osc_stop     (osc_stop),
      .cnt_last     (cnt_last),
      .mode_q       (mode_q),
      .warm_load    (warm_load),
      .warm_run     (warm_run),
      .dom_en       (dom_en),
      .wake_pending (wake_pending)
   );

   assign cpu_clk_en = dom_en.cpu;
   assign io_clk_en  = dom_en.io;
   assign adc_clk_en = dom_en.adc;
   assign tmr_clk_en = dom_en.tmr;
   assign wdt_clk_en = dom_en.wdt;
   assign osc_en     = dom_en.osc;

   // R7: the watchdog keeps its own clock in every state
   a_r7_wdt_always: assert property (@(posedge clk) disable iff (!rst_n) wdt_clk_en)
      else $error("R7: watchdog enable dropped");

endmodule

// File: tb/slp_clock_gate_ctrl_test.sv
module slp_clock_gate_ctrl_test;

   localparam int CLK_P = 10;
   localparam int CW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode_sel = '0;
   logic          sleep_en = 1'b0, sleep_req = 1'b0;
   logic          wake_ext = 1'b0, wake_twi = 1'b0, wake_wdt = 1'b0, wake_tmr = 1'b0;
   logic [CW-1:0] startup_cycles = '0;
   logic          cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, wdt_clk_en, osc_en, wake_pending;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   slp_clock_gate_ctrl #(.CNT_W(CW), .WAKE_SYNC(2)) uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en), .sleep_req(sleep_req),
      .wake_ext(wake_ext), .wake_twi(wake_twi), .wake_wdt(wake_wdt), .wake_tmr(wake_tmr),
      .startup_cycles(startup_cycles), .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en),
      .adc_clk_en(adc_clk_en), .tmr_clk_en(tmr_clk_en), .wdt_clk_en(wdt_clk_en),
      .osc_en(osc_en), .wake_pending(wake_pending)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // {cpu, io, adc, tmr, wdt, osc} surviving in each mode
   function automatic logic [5:0] keep_of(int m);
      case (m)
         1: return 6'b001111;
         2: return 6'b000010;
         3: return 6'b000110;
         6: return 6'b000011;
         7: return 6'b000111;
         default: return 6'b011111;
      endcase
   endfunction

   // accepted sources {ext, twi, wdt, tmr}
   function automatic logic [3:0] legal_of(int m);
      case (m)
         1: return 4'b1011;
         2, 6: return 4'b1110;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic string tag_of(int m);
      case (m)
         1: return "R4";
         2: return "R5";
         3: return "R6";
         6, 7: return "R7";
         default: return "R3";
      endcase
   endfunction

   // behavioural reference: 0 running, 1 asleep, 2 warming
   int         ms = 0, mm = 0, mc = 0;
   logic [3:0] s1 = '0, s2 = '0;
   bit         mp = 1'b0, armed = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mm = 0; mc = 0; s1 = '0; s2 = '0; mp = 1'b0; armed = 1'b1;
      end else begin
         bit np;
         np = 1'b0;
         if (ms == 0) begin
            if (sleep_req && sleep_en) begin ms = 1; mm = int'(mode_sel); end
         end else if (ms == 1) begin
            if ((s2 & legal_of(mm)) != 4'b0) begin
               if (mm == 2 || mm == 3) begin ms = 2; mc = int'(startup_cycles); end
               else begin ms = 0; np = 1'b1; end
            end
         end else begin
            if (mc <= 1) begin ms = 0; np = 1'b1; end
            else mc = mc - 1;
         end
         s2 = s1;
         s1 = {wake_ext, wake_twi, wake_wdt, wake_tmr};
         mp = np;
      end
   end

   always @(negedge clk) begin
      if (armed && rst_n) begin
         logic [5:0] e;
         string t;
         if (ms == 0)      begin e = 6'h3f; t = mp ? "R12" : "R2"; end
         else if (ms == 1) begin e = keep_of(mm); t = tag_of(mm); end
         else              begin e = {3'b000, keep_of(mm)[2], 2'b11}; t = "R10"; end
         chk(t, {cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, wdt_clk_en, osc_en, wake_pending},
             {e, mp});
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic visit(int code, logic [3:0] bad, int n_start, int warm);
      int n;
      mode_sel = 3'(code); sleep_en = 1'b1; sleep_req = 1'b1;
      cyc();
      sleep_req = 1'b0; mode_sel = ~3'(code);
      @(negedge clk);
      chk(tag_of(code), {26'b0, cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, wdt_clk_en, osc_en},
          {26'b0, keep_of(code)});
      cyc();
      sleep_req = 1'b1;            // R13: strobe and new code while asleep
      cyc();
      sleep_req = 1'b0;
      @(negedge clk);
      chk("R13", {26'b0, cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, wdt_clk_en, osc_en},
          {26'b0, keep_of(code)});
      if (bad != 4'b0) begin
         cyc();
         {wake_ext, wake_twi, wake_wdt, wake_tmr} = bad;
         repeat (4) cyc();
         {wake_ext, wake_twi, wake_wdt, wake_tmr} = 4'b0;
         repeat (3) cyc();
         @(negedge clk);
         chk("R8", {31'b0, cpu_clk_en}, 32'd0);
      end
      cyc();
      startup_cycles = CW'(n_start);
      wake_ext = 1'b1;
      cyc();
      wake_ext = 1'b0;
      n = 1;
      @(negedge clk);
      chk("R9", {31'b0, cpu_clk_en}, 32'd0);
      while (!cpu_clk_en && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk(warm != 0 ? "R10" : "R11", n, 3 + warm);
      chk("R12", {31'b0, wake_pending}, 32'd1);
      @(negedge clk);
      chk("R12", {31'b0, wake_pending}, 32'd0);
      cyc();
   endtask

   initial begin
      repeat (3) cyc();
      @(negedge clk);
      chk("R1", {25'b0, cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, wdt_clk_en, osc_en, wake_pending},
          32'h7e);
      cyc();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {25'b0, cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, wdt_clk_en, osc_en, wake_pending},
          32'h7e);
      cyc();
      // R2: strobe without enable
      sleep_en = 1'b0; sleep_req = 1'b1;
      cyc();
      sleep_req = 1'b0;
      @(negedge clk);
      chk("R2", {31'b0, cpu_clk_en}, 32'd1);
      cyc();

      visit(0, 4'b0000, 0, 0);
      visit(1, 4'b0100, 0, 0);
      visit(2, 4'b0001, 5, 5);
      visit(3, 4'b0000, 0, 1);
      visit(4, 4'b0000, 0, 0);
      visit(5, 4'b0000, 0, 0);
      visit(6, 4'b0001, 0, 0);
      visit(7, 4'b0000, 0, 0);
      visit(2, 4'b0000, 1, 1);

      // same-cycle case: wake already held when the strobe is taken
      wake_tmr = 1'b1;
      repeat (3) cyc();
      mode_sel = 3'd0; sleep_en = 1'b1; sleep_req = 1'b1;
      cyc();
      sleep_req = 1'b0;
      @(negedge clk);
      chk("R2", {31'b0, cpu_clk_en}, 32'd0);
      cyc();
      wake_tmr = 1'b0; mode_sel = 3'd6; sleep_req = 1'b1;
      @(negedge clk);
      chk("R12", {31'b0, wake_pending}, 32'd1);
      cyc();
      sleep_req = 1'b0;
      repeat (3) cyc();
      @(negedge clk);
      chk("R8", {30'b0, cpu_clk_en, osc_en}, 32'd1);
      cyc();
      wake_twi = 1'b1;
      cyc();
      wake_twi = 1'b0;
      repeat (3) cyc();
      @(negedge clk);
      chk("R11", {31'b0, cpu_clk_en}, 32'd1);
      repeat (4) cyc();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule